// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides, in the same cycle, whether an instruction runs. It reads the 4-bit condition field from the top of a 32-bit instruction word and the four arithmetic flags (negative, zero, carry, overflow) from a 32-bit status word. It drives an execute-enable bit and an undefined-instruction flag. It does not update flags and does not raise exceptions. It sits between fetch and issue, so that a predicated instruction whose test fails can be turned into a no-op.

The fourteen predicated codes form seven pairs. Each even code names a test on the flags. The odd code just above it is the inverse of that test. The block computes seven base tests once and derives the odd codes by inverting them. The remaining two codes are special. One means "run unconditionally". The other is reserved: it is reported on the undefined-instruction output, not as a plain failed test.

Top module: `cond_exec_gate`

## Requirements
- R1: The condition code is taken only from instruction bits [31:28]. Instruction bits [27:0] have no effect on either output.
- R2: The flags are read from status bits 31 (N), 30 (Z), 29 (C) and 28 (V). Status bits [27:0] have no effect on either output.
- R3: Code 0x0 executes when Z=1. Code 0x1 executes when Z=0.
- R4: Code 0x2 executes when C=1. Code 0x3 executes when C=0.
- R5: Code 0x4 executes when N=1. Code 0x5 executes when N=0.
- R6: Code 0x6 executes when V=1. Code 0x7 executes when V=0.
- R7: Code 0x8 executes when C=1 and Z=0. Code 0x9 executes in every other flag state.
- R8: Code 0xA executes when N equals V. Code 0xB executes when N differs from V.
- R9: Code 0xC executes when N equals V and Z=0. Code 0xD executes in every other flag state.
- R10: Code 0xE sets execute-enable to 1 for all flag values.
- R11: Code 0xF sets the undefined-instruction flag to 1 and execute-enable to 0, whatever the flags are.
- R12: For codes 0x0 to 0xE the undefined-instruction flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 32 | Instruction word; the condition code is in bits [31:28] |
| status_word | input | 32 | Status word; the flags are in bits [31:28] |
| exec_en | output | 1 | 1 when the instruction passes its condition |
| undef_instr | output | 1 | 1 when the condition code is reserved |

## Verification
Both results are purely combinational, so they are due in the cycle in which the inputs change, with no register in the path. The driver applies each instruction and status pair on a falling clock edge and pushes the expected pair into a queue. The monitor pops that entry at the next rising edge, half a period later, once the outputs have settled. The sweep covers all 16 codes against all 16 flag states, with changing noise in the low bits. A further pass holds the code and flags fixed while only the low bits of the instruction and status words change.

// File: rtl/cc_eval_pkg.sv
package cc_eval_pkg;

   localparam int unsigned CODE_W    = 4;
   localparam int unsigned NUM_PAIRS = 7;
   localparam int unsigned NUM_CODES = 1 << CODE_W;

   typedef struct packed {
      logic neg;
      logic zero;
      logic carry;
      logic ovf;
   } cc_flags_t;

   // Only the even member of each pair is named; the odd one is its inverse.
   typedef enum logic [CODE_W-1:0] {
      CC_ZSET   = 4'h0,
      CC_CSET   = 4'h2,
      CC_NSET   = 4'h4,
      CC_VSET   = 4'h6,
      CC_UHIGH  = 4'h8,
      CC_SGE    = 4'hA,
      CC_SGT    = 4'hC,
      CC_ALWAYS = 4'hE,
      CC_RSVD   = 4'hF
   } cc_code_e;

endpackage

// File: rtl/cc_flag_pick.sv
module cc_flag_pick
   import cc_eval_pkg::*;
#(
   parameter int unsigned STATUS_W = 32,
   parameter int unsigned N_POS    = 31,
   parameter int unsigned Z_POS    = 30,
   parameter int unsigned C_POS    = 29,
   parameter int unsigned V_POS    = 28
) (
   input  logic [STATUS_W-1:0] status,
   output cc_flags_t           flags
);

   if (N_POS >= STATUS_W || Z_POS >= STATUS_W ||
       C_POS >= STATUS_W || V_POS >= STATUS_W) begin : g_bad_pos
      $error("cc_flag_pick: flag position outside status word");
   end

   always_comb begin
      flags.neg   = status[N_POS];
      flags.zero  = status[Z_POS];
      flags.carry = status[C_POS];
      flags.ovf   = status[V_POS];
   end

endmodule

// File: rtl/cc_pair_tests.sv
module cc_pair_tests
   import cc_eval_pkg::*;
(
   input  cc_flags_t              flags,
   output logic [NUM_PAIRS-1:0]   base
);

   logic sign_match;

   always_comb begin
      sign_match = ~(flags.neg ^ flags.ovf);
      base[0] = flags.zero;                      // equal
      base[1] = flags.carry;                     // carry set
      base[2] = flags.neg;                       // negative
      base[3] = flags.ovf;                       // overflow
      base[4] = flags.carry & ~flags.zero;       // unsigned higher
      base[5] = sign_match;                      // signed >=
      base[6] = sign_match & ~flags.zero;        // signed >
   end

endmodule

// File: rtl/cc_code_select.sv
module cc_code_select
   import cc_eval_pkg::*;
#(
   parameter logic [CODE_W-1:0] ALWAYS_CODE  = 4'hE,
   parameter logic [CODE_W-1:0] RESERVED_CODE = 4'hF,
   parameter int unsigned       SELECT_STYLE = 0   // 0: indexed pair vector, 1: case decode
) (
   input  logic [CODE_W-1:0]    code,
   input  logic [NUM_PAIRS-1:0] base,
   output logic                 exec,
   output logic                 undef
);

   localparam int unsigned PAIR_IDX_W = CODE_W - 1;

   if (ALWAYS_CODE == RESERVED_CODE) begin : g_bad_codes
      $error("cc_code_select: always and reserved codes must differ");
   end
   if (SELECT_STYLE > 1) begin : g_bad_style
      $error("cc_code_select: SELECT_STYLE must be 0 or 1");
   end

   logic is_always;
   logic is_rsvd;

   always_comb begin
      is_always = (code == ALWAYS_CODE);
      is_rsvd   = (code == RESERVED_CODE);
   end

   if (SELECT_STYLE == 0) begin : g_indexed
      logic [NUM_CODES-1:0] hit;
      for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
         assign hit[2*k]     =  base[k];
         assign hit[2*k + 1] = ~base[k];
      end
      assign hit[NUM_CODES-2] = 1'b1;
      assign hit[NUM_CODES-1] = 1'b0;

      always_comb begin
         exec  = is_always | (~is_rsvd & hit[code]);
         undef = is_rsvd;
      end
   end else begin : g_decode
      logic [PAIR_IDX_W-1:0] pair_idx;
      logic                  pair_val;
      always_comb begin
         pair_idx = code[CODE_W-1:1];
         pair_val = 1'b0;
         case (pair_idx)
            3'd0:    pair_val = base[0];
            3'd1:    pair_val = base[1];
            3'd2:    pair_val = base[2];
            3'd3:    pair_val = base[3];
            3'd4:    pair_val = base[4];
            3'd5:    pair_val = base[5];
            3'd6:    pair_val = base[6];
            default: pair_val = 1'b0;
         endcase
         if (is_rsvd) begin
            exec = 1'b0;
         end else if (is_always) begin
            exec = 1'b1;
         end else begin
            exec = pair_val ^ code[0];
         end
         undef = is_rsvd;
      end
   end

   always_comb begin
      if (code == RESERVED_CODE) begin
         p_reserved_blocks_r11: assert (undef && !exec)
            else $error("reserved code did not raise undef with exec low");
      end
      if (code == ALWAYS_CODE) begin
         p_always_runs_r10: assert (exec && !undef)
            else $error("always code did not execute");
      end
   end

endmodule

// File: rtl/cond_exec_gate.sv
module cond_exec_gate
   import cc_eval_pkg::*;
#(
   parameter int unsigned INSTR_W      = 32,
   parameter int unsigned STATUS_W     = 32,
   parameter int unsigned CODE_MSB     = 31,
   parameter int unsigned N_POS        = 31,
   parameter int unsigned Z_POS        = 30,
   parameter int unsigned C_POS        = 29,
   parameter int unsigned V_POS        = 28,
   parameter int unsigned SELECT_STYLE = 0
) (
   input  logic [INSTR_W-1:0]  instr_word,
   input  logic [STATUS_W-1:0] status_word,
   output logic                exec_en,
   output logic                undef_instr
);

   localparam int unsigned CODE_LSB = CODE_MSB - CODE_W + 1;

   if (CODE_MSB >= INSTR_W || CODE_MSB + 1 < CODE_W) begin : g_bad_field
      $error("cond_exec_gate: condition field outside instruction word");
   end

   logic [CODE_W-1:0]    code;
   cc_flags_t            flags;
   logic [NUM_PAIRS-1:0] base;

   assign code = instr_word[CODE_MSB:CODE_LSB];

   cc_flag_pick #(
      .STATUS_W (STATUS_W),
      .N_POS    (N_POS),
      .Z_POS    (Z_POS),
      .C_POS    (C_POS),
      .V_POS    (V_POS)
   ) u_flags (
      .status (status_word),
      .flags  (flags)
   );

   cc_pair_tests u_tests (
      .flags (flags),
      .base  (base)
   );

   cc_code_select #(
      .ALWAYS_CODE   (CC_ALWAYS),
      .RESERVED_CODE (CC_RSVD),
      .SELECT_STYLE  (SELECT_STYLE)
   ) u_sel (
      .code  (code),
      .base  (base),
      .exec  (exec_en),
      .undef (undef_instr)
   );

   always_comb begin
      p_undef_excl_r11: assert (!(undef_instr && exec_en))
         else $error("undef and exec both high");
      if (code != CC_RSVD) begin
         p_no_undef_r12: assert (!undef_instr)
            else $error("undef raised for a defined code");
      end
      if (code == CC_ZSET) begin
         p_eq_tracks_z_r3: assert (exec_en == status_word[Z_POS])
            else $error("equal code does not follow zero flag");
      end
      if (code == CC_SGE) begin
         p_ge_tracks_nv_r8: assert (exec_en == (status_word[N_POS] == status_word[V_POS]))
            else $error("signed >= code does not follow N and V");
      end
   end

endmodule

// File: tb/cond_exec_gate_test.sv
module cond_exec_gate_test;

   typedef struct {
      logic  exp_exec;
      logic  exp_undef;
      string tag_exec;
      string tag_undef;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr_word  = 32'h0;
   logic [31:0] status_word = 32'h0;
   logic        exec_en;
   logic        undef_instr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   item_t sb_q[$];
   item_t cur;

   always #5 clk = ~clk;

   cond_exec_gate uut (
      .instr_word  (instr_word),
      .status_word (status_word),
      .exec_en     (exec_en),
      .undef_instr (undef_instr)
   );

   function automatic logic ref_exec(input logic [3:0] cc, input logic [3:0] f);
      logic n, z, c, v;
      n = f[3]; z = f[2]; c = f[1]; v = f[0];
      case (cc)
         4'h0: ref_exec = z;
         4'h1: ref_exec = !z;
         4'h2: ref_exec = c;
         4'h3: ref_exec = !c;
         4'h4: ref_exec = n;
         4'h5: ref_exec = !n;
         4'h6: ref_exec = v;
         4'h7: ref_exec = !v;
         4'h8: ref_exec = c && !z;
         4'h9: ref_exec = !c || z;
         4'hA: ref_exec = (n == v);
         4'hB: ref_exec = (n != v);
         4'hC: ref_exec = (n == v) && !z;
         4'hD: ref_exec = (n != v) || z;
         4'hE: ref_exec = 1'b1;
         default: ref_exec = 1'b0;
      endcase
   endfunction

   function automatic string code_tag(input logic [3:0] cc);
      case (cc)
         4'h0, 4'h1: code_tag = "R3";
         4'h2, 4'h3: code_tag = "R4";
         4'h4, 4'h5: code_tag = "R5";
         4'h6, 4'h7: code_tag = "R6";
         4'h8, 4'h9: code_tag = "R7";
         4'hA, 4'hB: code_tag = "R8";
         4'hC, 4'hD: code_tag = "R9";
         4'hE:       code_tag = "R10";
         default:    code_tag = "R11";
      endcase
   endfunction

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b (instr %h status %h)",
                  tag, what, act, exp, instr_word, status_word);
      end
   endtask

   task automatic apply(input logic [31:0] ins, input logic [31:0] st,
                        input string te, input string tu);
      item_t it;
      @(negedge clk);
      instr_word  = ins;
      status_word = st;
      it.exp_exec  = ref_exec(ins[31:28], st[31:28]);
      it.exp_undef = (ins[31:28] == 4'hF);
      it.tag_exec  = te;
      it.tag_undef = tu;
      sb_q.push_back(it);
   endtask

   // Monitor: outputs are combinational, compared half a period after the drive.
   always @(posedge clk) begin
      if (!rst && sb_q.size() > 0) begin
         cur = sb_q.pop_front();
         check(cur.tag_exec,  "exec_en",     exec_en,     cur.exp_exec);
         check(cur.tag_undef, "undef_instr", undef_instr, cur.exp_undef);
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: all-zero inputs give code 0x0 with Z=0
      check("R3",  "exec_en at reset",     exec_en,     1'b0);
      check("R12", "undef_instr at reset", undef_instr, 1'b0);
      rst = 1'b0;

      // Full sweep of codes against flag states, with noise in the low bits
      for (int cc = 0; cc < 16; cc++) begin
         for (int fl = 0; fl < 16; fl++) begin
            logic [31:0] noise_i;
            logic [31:0] noise_s;
            noise_i = (cc * 16 + fl) * 32'h9E3779B1;
            noise_s = (cc * 16 + fl + 7) * 32'h85EBCA6B;
            apply({cc[3:0], noise_i[27:0]}, {fl[3:0], noise_s[27:0]},
                  code_tag(cc[3:0]), (cc == 15) ? "R11" : "R12");
         end
      end

      // R1: only low instruction bits change
      for (int k = 0; k < 8; k++) begin
         logic [31:0] lo;
         lo = (k + 1) * 32'hC2B2AE35;
         apply({4'h8, lo[27:0]}, 32'h2000_0000, "R1", "R1");
         apply({4'hF, ~lo[27:0]}, 32'hF000_0000, "R1", "R1");
      end
      // R2: only low status bits change
      for (int k = 0; k < 8; k++) begin
         logic [31:0] lo;
         lo = (k + 3) * 32'h27D4EB2F;
         apply(32'h0000_0000, {4'h0, lo[27:0]}, "R2", "R2");
         apply(32'hA000_0000, {4'h9, ~lo[27:0]}, "R2", "R2");
      end

      repeat (3) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule